// File: doc/BRIEF.md
# Core Run-State Controller

This block tracks the run state of a single processor core subsystem. The core is in one of four states: Execution, Debug, STOP or WAIT. While in Execution it is also in one of three sub-modes: Normal, Exception or Protected. The inputs are pulses from the surrounding logic:
- decoded instruction strobes;
- a debug request and a debug exit from the JTAG host;
- an external event pin with a programmable direction;
- event pulses from the emulation and debug units.

From these the block decides when the core halts for a debugger, when it sleeps, and when it wakes. Its outputs are a one-hot state vector, the core clock enable, a debug-acknowledge flag, the latched cause of the most recent Debug entry, and a one-cycle debug-exception request.

The low-power states can only be entered from the non-protected sub-modes. A configuration bit selects what a wake-up event does while the core sleeps. With the bit clear, the core halts in Debug state. With the bit set, the core resumes Execution and a debug exception is requested instead. The external pin passes through a synchroniser whose depth is a parameter. The default depth is two stages, so a pin event acts three clock edges after it is driven. Every other input acts on the next edge.

Top module: `core_run_ctrl`

## Requirements
- R1: After reset the state is Execution in Normal mode, the pin is configured as an input, the wake policy is Debug, the recorded cause is 0, and the exception request is low.
- R2: `state_oh_o` has exactly one bit set: bit 0 is Execution, bit 1 is Debug, bit 2 is STOP and bit 3 is WAIT. `core_clk_en_o` is high in Execution and Debug and low in STOP and WAIT. `dbg_ack_o` is high only in Debug.
- R3: From Execution, the block enters Debug on any of these: a JTAG debug request; an external pin event while the pin is an input; any bit of `emu_evt_i`; or a DEBUG or DEBUGEV strobe while `instr_dbg_en_i` is high. The pin acts after EXT_SYNC_STAGES+1 edges and every other trigger after one edge.
- R4: A pin event is ignored while the pin is configured as an output. DEBUG and DEBUGEV strobes are ignored while `instr_dbg_en_i` is low.
- R5: `dbg_cause_o` is loaded on every Debug entry with 0 for JTAG, 1 for the pin, 2 for an emulation event and 3 for an instruction. When triggers coincide, JTAG wins over the pin, the pin over emulation events, and emulation events over instructions.
- R6: In Execution Normal (mode 00) or Exception (mode 01), a STOP strobe enters STOP and a WAIT strobe enters WAIT. STOP wins over WAIT, and a debug trigger wins over both.
- R7: In a Protected mode (mode 10 or 11), STOP and WAIT strobes leave the state unchanged.
- R8: STOP and WAIT are left only on a JTAG debug request or on a pin event while the pin is an input. Emulation events and instruction strobes have no effect in these states.
- R9: With the policy bit clear, a wake-up goes to Debug. With it set, a wake-up returns to Execution with the sub-mode unchanged and `dbg_exc_req_o` high for exactly one cycle.
- R10: In Debug, `jtag_dbg_exit_i` returns the block to Execution in Normal mode.
- R11: `mode_wr_i` loads `mode_val_i` into the sub-mode (00 Normal, 01 Exception, 10 or 11 Protected) only while the block stays in Execution. It is ignored in the other states.
- R12: `cfg_wr_i` loads the pin direction (`cfg_pin_out_i` = 1 means output) and the wake policy (`cfg_policy_exc_i` = 1 means exception), effective from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_stop_i | input | 1 | STOP instruction strobe |
| instr_wait_i | input | 1 | WAIT instruction strobe |
| instr_debug_i | input | 1 | DEBUG instruction strobe |
| instr_debugev_i | input | 1 | DEBUGEV instruction strobe |
| instr_dbg_en_i | input | 1 | Emulation setting enabling the debug instructions |
| jtag_dbg_req_i | input | 1 | Debug request from the JTAG host |
| jtag_dbg_exit_i | input | 1 | Debug exit from the JTAG host |
| ext_evt_i | input | 1 | External event pin, asynchronous |
| emu_evt_i | input | N_EMU_SRC | Emulation and debug-unit event pulses |
| cfg_wr_i | input | 1 | Configuration load strobe |
| cfg_pin_out_i | input | 1 | Pin direction to load, 1 = output |
| cfg_policy_exc_i | input | 1 | Wake policy to load, 1 = exception |
| mode_wr_i | input | 1 | Sub-mode load strobe |
| mode_val_i | input | 2 | Sub-mode value to load |
| state_oh_o | output | 4 | One-hot run state |
| exec_mode_o | output | 2 | Current Execution sub-mode |
| dbg_cause_o | output | 2 | Cause of the last Debug entry |
| core_clk_en_o | output | 1 | Core clock enable |
| dbg_exc_req_o | output | 1 | One-cycle debug-exception request |
| dbg_ack_o | output | 1 | Debug state acknowledge |

## Verification
A corrupted state register shows up on `state_oh_o` and `core_clk_en_o` at the edge where it happens. Two examples are a core left clocked in STOP and a Debug state without acknowledge. A wrong sub-mode or policy value stays hidden until the next STOP or WAIT strobe or the next wake-up. At that point the core either sleeps when it should not, or it returns to the wrong place, one edge later. A wrong priority decision shows up only in `dbg_cause_o`, on the edge after the coinciding triggers, so each ordering is driven on purpose.

// File: rtl/cprc_pkg.sv
package cprc_pkg;
   // One-hot bit positions of the run state
   localparam int ST_W     = 4;
   localparam int ST_EXEC  = 0;
   localparam int ST_DEBUG = 1;
   localparam int ST_STOP  = 2;
   localparam int ST_WAIT  = 3;

   localparam logic [ST_W-1:0] ST_RESET = 4'b0001;

   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'b00,
      MODE_EXCEPT   = 2'b01,
      MODE_PROT     = 2'b10,
      MODE_PROT_ALT = 2'b11
   } exec_mode_e;

   typedef enum logic [1:0] {
      CAUSE_JTAG  = 2'd0,
      CAUSE_PIN   = 2'd1,
      CAUSE_EMU   = 2'd2,
      CAUSE_INSTR = 2'd3
   } dbg_cause_e;

   function automatic logic mode_is_protected(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/cprc_ext_sync.sv
module cprc_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("cprc_ext_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= d_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], d_i};
         end
      end
      assign q_o = sync_q[STAGES-1];
   end
endmodule

// File: rtl/cprc_cfg_reg.sv
module cprc_cfg_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic pin_out_i,
   input  logic policy_exc_i,
   output logic pin_out_o,
   output logic policy_exc_o
);
   // Pin defaults to input, wake policy defaults to Debug
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out_o    <= 1'b0;
         policy_exc_o <= 1'b0;
      end else if (wr_i) begin
         pin_out_o    <= pin_out_i;
         policy_exc_o <= policy_exc_i;
      end
   end
endmodule

// File: rtl/cprc_trig_arb.sv
module cprc_trig_arb
   import cprc_pkg::*;
#(
   parameter int N_EMU_SRC = 2
) (
   input  logic                 jtag_req_i,
   input  logic                 pin_evt_i,
   input  logic [N_EMU_SRC-1:0] emu_evt_i,
   input  logic                 instr_dbg_i,
   output logic                 hit_o,
   output logic [1:0]           cause_o
);
   logic emu_any;
   assign emu_any = |emu_evt_i;
   assign hit_o   = jtag_req_i | pin_evt_i | emu_any | instr_dbg_i;

   // Fixed priority: host, pin, emulation, instruction
   always_comb begin
      if (jtag_req_i)     cause_o = CAUSE_JTAG;
      else if (pin_evt_i) cause_o = CAUSE_PIN;
      else if (emu_any)   cause_o = CAUSE_EMU;
      else                cause_o = CAUSE_INSTR;
   end
endmodule

// File: rtl/cprc_state_fsm.sv
module cprc_state_fsm
   import cprc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dbg_hit_i,
   input  logic [1:0]      dbg_cause_i,
   input  logic            jtag_req_i,
   input  logic            pin_evt_i,
   input  logic            stop_i,
   input  logic            wait_i,
   input  logic            exit_i,
   input  logic            mode_wr_i,
   input  logic [1:0]      mode_val_i,
   input  logic            policy_exc_i,
   output logic [ST_W-1:0] state_o,
   output logic [1:0]      mode_o,
   output logic [1:0]      cause_o,
   output logic            exc_req_o
);
   logic [ST_W-1:0] state_n;
   logic [1:0]      mode_n;
   logic [1:0]      cause_n;
   logic            exc_n;
   logic            lp_allowed;
   logic            wake;

   assign lp_allowed = !mode_is_protected(mode_o);
   assign wake       = jtag_req_i | pin_evt_i;

   always_comb begin
      state_n = state_o;
      mode_n  = mode_o;
      cause_n = cause_o;
      exc_n   = 1'b0;
      case (1'b1)
         state_o[ST_EXEC]: begin
            if (dbg_hit_i) begin
               state_n = 4'b0010;
               cause_n = dbg_cause_i;
            end else if (lp_allowed && stop_i) begin
               state_n = 4'b0100;
            end else if (lp_allowed && wait_i) begin
               state_n = 4'b1000;
            end else if (mode_wr_i) begin
               mode_n = mode_val_i;
            end
         end
         state_o[ST_DEBUG]: begin
            if (exit_i) begin
               state_n = 4'b0001;
               mode_n  = MODE_NORMAL;
            end
         end
         state_o[ST_STOP], state_o[ST_WAIT]: begin
            if (wake) begin
               if (policy_exc_i) begin
                  state_n = 4'b0001;
                  exc_n   = 1'b1;
               end else begin
                  state_n = 4'b0010;
                  cause_n = jtag_req_i ? CAUSE_JTAG : CAUSE_PIN;
               end
            end
         end
         default: state_n = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o   <= ST_RESET;
         mode_o    <= MODE_NORMAL;
         cause_o   <= CAUSE_JTAG;
         exc_req_o <= 1'b0;
      end else begin
         state_o   <= state_n;
         mode_o    <= mode_n;
         cause_o   <= cause_n;
         exc_req_o <= exc_n;
      end
   end
endmodule

// File: rtl/core_run_ctrl.sv
module core_run_ctrl
   import cprc_pkg::*;
#(
   parameter int N_EMU_SRC       = 2,
   parameter int EXT_SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_stop_i,
   input  logic                 instr_wait_i,
   input  logic                 instr_debug_i,
   input  logic                 instr_debugev_i,
   input  logic                 instr_dbg_en_i,
   input  logic                 jtag_dbg_req_i,
   input  logic                 jtag_dbg_exit_i,
   input  logic                 ext_evt_i,
   input  logic [N_EMU_SRC-1:0] emu_evt_i,
   input  logic                 cfg_wr_i,
   input  logic                 cfg_pin_out_i,
   input  logic                 cfg_policy_exc_i,
   input  logic                 mode_wr_i,
   input  logic [1:0]           mode_val_i,
   output logic [3:0]           state_oh_o,
   output logic [1:0]           exec_mode_o,
   output logic [1:0]           dbg_cause_o,
   output logic                 core_clk_en_o,
   output logic                 dbg_exc_req_o,
   output logic                 dbg_ack_o
);
   if (N_EMU_SRC < 1 || N_EMU_SRC > 32) begin : g_bad_emu
      $error("core_run_ctrl: N_EMU_SRC must be 1..32");
   end

   logic pin_sync;
   logic pin_out;
   logic policy_exc;
   logic pin_evt;
   logic instr_dbg;
   logic dbg_hit;
   logic [1:0] dbg_cause;
   logic [ST_W-1:0] state;

   cprc_ext_sync #(.STAGES(EXT_SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ext_evt_i), .q_o(pin_sync)
   );

   cprc_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i),
      .pin_out_i(cfg_pin_out_i), .policy_exc_i(cfg_policy_exc_i),
      .pin_out_o(pin_out), .policy_exc_o(policy_exc)
   );

   // The pin counts as an event only while it is an input
   assign pin_evt   = pin_sync & ~pin_out;
   assign instr_dbg = (instr_debug_i | instr_debugev_i) & instr_dbg_en_i;

   cprc_trig_arb #(.N_EMU_SRC(N_EMU_SRC)) u_arb (
      .jtag_req_i(jtag_dbg_req_i), .pin_evt_i(pin_evt),
      .emu_evt_i(emu_evt_i), .instr_dbg_i(instr_dbg),
      .hit_o(dbg_hit), .cause_o(dbg_cause)
   );

   cprc_state_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .dbg_hit_i(dbg_hit), .dbg_cause_i(dbg_cause),
      .jtag_req_i(jtag_dbg_req_i), .pin_evt_i(pin_evt),
      .stop_i(instr_stop_i), .wait_i(instr_wait_i),
      .exit_i(jtag_dbg_exit_i),
      .mode_wr_i(mode_wr_i), .mode_val_i(mode_val_i),
      .policy_exc_i(policy_exc),
      .state_o(state), .mode_o(exec_mode_o),
      .cause_o(dbg_cause_o), .exc_req_o(dbg_exc_req_o)
   );

   assign state_oh_o    = state;
   assign core_clk_en_o = state[ST_EXEC] | state[ST_DEBUG];
   assign dbg_ack_o     = state[ST_DEBUG];
endmodule

// File: rtl/core_run_ctrl_chk.sv
module core_run_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       jtag_dbg_req_i,
   input logic       jtag_dbg_exit_i,
   input logic [3:0] state_oh_o,
   input logic [1:0] exec_mode_o,
   input logic [1:0] dbg_cause_o,
   input logic       core_clk_en_o,
   input logic       dbg_exc_req_o,
   input logic       dbg_ack_o
);
   p_state_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh_o) == 1);

   p_clk_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[2] || state_oh_o[3]) |-> !core_clk_en_o);

   p_clk_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[0] || state_oh_o[1]) |-> core_clk_en_o);

   p_ack_in_debug_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack_o |-> state_oh_o[1]);

   p_jtag_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[0] && jtag_dbg_req_i) |=> (state_oh_o[1] && dbg_cause_o == 2'd0));

   p_protected_no_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[0] && exec_mode_o[1]) |=> !(state_oh_o[2] || state_oh_o[3]));

   p_exc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_exc_req_o |=> !dbg_exc_req_o);

   p_exc_from_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_exc_req_o |-> (state_oh_o[0] && ($past(state_oh_o[2]) || $past(state_oh_o[3]))));

   p_exit_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[1] && jtag_dbg_exit_i) |=> (state_oh_o[0] && exec_mode_o == 2'b00));

   p_mode_kept_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh_o[2] || state_oh_o[3]) |=> $stable(exec_mode_o));
endmodule

bind core_run_ctrl core_run_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .jtag_dbg_req_i(jtag_dbg_req_i), .jtag_dbg_exit_i(jtag_dbg_exit_i),
   .state_oh_o(state_oh_o), .exec_mode_o(exec_mode_o),
   .dbg_cause_o(dbg_cause_o), .core_clk_en_o(core_clk_en_o),
   .dbg_exc_req_o(dbg_exc_req_o), .dbg_ack_o(dbg_ack_o)
);

// File: tb/core_run_ctrl_tb.sv
`timescale 1ns/1ps
module core_run_ctrl_tb_top;
   localparam int N_EMU   = 2;
   localparam int SYNC    = 2;
   localparam int PIN_LAT = SYNC + 1;
   localparam logic [3:0] EXEC = 4'b0001, DBG = 4'b0010, STP = 4'b0100, WT = 4'b1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic istop = 0, iwait = 0, idebug = 0, idebugev = 0, dbg_en = 0;
   logic jreq = 0, jexit = 0, ext = 0;
   logic [N_EMU-1:0] emu = '0;
   logic cfg_wr = 0, cfg_pin_out = 0, cfg_policy = 0;
   logic mode_wr = 0;
   logic [1:0] mode_val = 2'b00;
   logic [3:0] st;
   logic [1:0] md, cs;
   logic clk_en, exc, ack;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   core_run_ctrl #(.N_EMU_SRC(N_EMU), .EXT_SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .instr_stop_i(istop), .instr_wait_i(iwait),
      .instr_debug_i(idebug), .instr_debugev_i(idebugev),
      .instr_dbg_en_i(dbg_en),
      .jtag_dbg_req_i(jreq), .jtag_dbg_exit_i(jexit),
      .ext_evt_i(ext), .emu_evt_i(emu),
      .cfg_wr_i(cfg_wr), .cfg_pin_out_i(cfg_pin_out), .cfg_policy_exc_i(cfg_policy),
      .mode_wr_i(mode_wr), .mode_val_i(mode_val),
      .state_oh_o(st), .exec_mode_o(md), .dbg_cause_o(cs),
      .core_clk_en_o(clk_en), .dbg_exc_req_o(exc), .dbg_ack_o(ack)
   );

   typedef struct {
      int         due;
      logic [3:0] st;
      logic [1:0] md;
      logic [1:0] cs;
      logic       ex;
      string      tag;
   } exp_t;
   exp_t q[$];

   task automatic compare(input exp_t e);
      logic exp_clk, exp_ack;
      exp_clk = e.st[0] | e.st[1];   // R2 clock enable rule
      exp_ack = e.st[1];
      checks++;
      if (st !== e.st || md !== e.md || cs !== e.cs || exc !== e.ex ||
          clk_en !== exp_clk || ack !== exp_ack) begin
         errors++;
         $display("FAIL %s: act st=%b md=%b cs=%0d exc=%b clk_en=%b ack=%b exp st=%b md=%b cs=%0d exc=%b clk_en=%b ack=%b",
                  e.tag, st, md, cs, exc, clk_en, ack, e.st, e.md, e.cs, e.ex, exp_clk, exp_ack);
      end
   endtask

   // Monitor: pops expectations when their cycle arrives
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         if (e.due < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s: act missed cycle %0d exp cycle %0d", e.tag, cyc, e.due);
         end else begin
            compare(e);
         end
      end
   end

   task automatic expect_after(input int lat, input logic [3:0] s, input logic [1:0] m,
                               input logic [1:0] c, input logic x, input string tag);
      exp_t e;
      e.due = cyc + lat; e.st = s; e.md = m; e.cs = c; e.ex = x; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      istop = 0; iwait = 0; idebug = 0; idebugev = 0;
      jreq = 0; jexit = 0; ext = 0; emu = '0; cfg_wr = 0; mode_wr = 0;
   endtask

   task automatic do_exit(input logic [1:0] c);
      jexit = 1;
      expect_after(1, EXEC, 2'b00, c, 0, "R10 exit to normal");
      step();
   endtask

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      r.due = cyc; r.st = EXEC; r.md = 2'b00; r.cs = 2'd0; r.ex = 0; r.tag = "R1 reset state";
      compare(r);

      // R3 entry triggers
      jreq = 1; expect_after(1, DBG, 0, 0, 0, "R3 jtag entry"); step();
      do_exit(0);
      emu = 2'b10; expect_after(1, DBG, 0, 2, 0, "R3 emu entry"); step();
      do_exit(2);
      idebug = 1; expect_after(1, EXEC, 0, 2, 0, "R4 instr masked"); step();
      dbg_en = 1;
      idebugev = 1; expect_after(1, DBG, 0, 3, 0, "R3 debugev entry"); step();
      do_exit(3);

      // R5 priority
      jreq = 1; emu = 2'b01; idebug = 1;
      expect_after(1, DBG, 0, 0, 0, "R5 jtag over all"); step();
      do_exit(0);
      emu = 2'b01; idebug = 1;
      expect_after(1, DBG, 0, 2, 0, "R5 emu over instr"); step();
      do_exit(2);

      // R3 pin path
      ext = 1; expect_after(PIN_LAT, DBG, 0, 1, 0, "R3 pin entry");
      step(); step(); step();
      do_exit(1);
      ext = 1; step(); step();
      emu = 2'b11; idebug = 1;
      expect_after(1, DBG, 0, 1, 0, "R5 pin over emu"); step();
      do_exit(1);

      // R4 / R12 pin configured as output
      cfg_wr = 1; cfg_pin_out = 1; cfg_policy = 0;
      expect_after(1, EXEC, 0, 1, 0, "R12 cfg write"); step();
      ext = 1; step(); step();
      expect_after(1, EXEC, 0, 1, 0, "R4 pin ignored as output"); step();
      cfg_wr = 1; cfg_pin_out = 0; step();

      // R11 / R6 WAIT
      mode_wr = 1; mode_val = 2'b01;
      expect_after(1, EXEC, 1, 1, 0, "R11 mode exception"); step();
      iwait = 1; expect_after(1, WT, 1, 1, 0, "R6 wait entry"); step();
      emu = 2'b11; idebug = 1; istop = 1;
      expect_after(1, WT, 1, 1, 0, "R8 events ignored in wait"); step();
      jreq = 1; expect_after(1, DBG, 1, 0, 0, "R9 wake to debug"); step();
      mode_wr = 1; mode_val = 2'b10;
      expect_after(1, DBG, 1, 0, 0, "R11 mode write ignored in debug"); step();
      do_exit(0);

      // R6 STOP over WAIT, R8 pin wake
      istop = 1; iwait = 1; expect_after(1, STP, 0, 0, 0, "R6 stop over wait"); step();
      emu = 2'b01; expect_after(1, STP, 0, 0, 0, "R8 emu ignored in stop"); step();
      ext = 1; expect_after(PIN_LAT, DBG, 0, 1, 0, "R8 pin wakes stop");
      step(); step(); step();
      do_exit(1);

      // R7 protected modes
      mode_wr = 1; mode_val = 2'b10;
      expect_after(1, EXEC, 2, 1, 0, "R11 mode protected"); step();
      istop = 1; expect_after(1, EXEC, 2, 1, 0, "R7 stop blocked"); step();
      iwait = 1; expect_after(1, EXEC, 2, 1, 0, "R7 wait blocked"); step();
      mode_wr = 1; mode_val = 2'b11;
      expect_after(1, EXEC, 3, 1, 0, "R11 mode protected alt"); step();
      istop = 1; expect_after(1, EXEC, 3, 1, 0, "R7 stop blocked alt"); step();
      mode_wr = 1; mode_val = 2'b00;
      expect_after(1, EXEC, 0, 1, 0, "R11 mode normal"); step();
      jreq = 1; istop = 1;
      expect_after(1, DBG, 0, 0, 0, "R6 debug over stop"); step();
      do_exit(0);

      // R9 exception policy
      cfg_wr = 1; cfg_policy = 1; step();
      mode_wr = 1; mode_val = 2'b01;
      expect_after(1, EXEC, 1, 0, 0, "R11 mode exception"); step();
      istop = 1; expect_after(1, STP, 1, 0, 0, "R6 stop entry"); step();
      jreq = 1; expect_after(1, EXEC, 1, 0, 1, "R9 exception wake"); step();
      expect_after(1, EXEC, 1, 0, 0, "R9 single pulse"); step();
      iwait = 1; expect_after(1, WT, 1, 0, 0, "R6 wait entry"); step();
      ext = 1; expect_after(PIN_LAT, EXEC, 1, 0, 1, "R9 pin exception wake");
      step(); step(); step();
      expect_after(1, EXEC, 1, 0, 0, "R9 single pulse pin"); step();
      jreq = 1; expect_after(1, DBG, 1, 0, 0, "R3 policy no effect in exec"); step();
      do_exit(0);

      step(); step();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         #2_000_000;
      join_any
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: act hung exp completion");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule